// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

This block accepts an FPGA configuration stream, one 32-bit word per cycle, over a valid/ready input. It hunts for the synchronisation word and then parses packet headers. Payload words go to a small register set: checksum, frame address, command, control and mask. Frame-data words are not stored. They leave on a streaming output tagged with the current frame address. Each recognised command code produces a one-cycle strobe on its own output bit. A command that ends the session sends the parser back to hunting for the next synchronisation word.

The decoder is built around a three-state machine:
- **SEARCH** discards words until the synchronisation word arrives. This transition is *sync-found*.
- **HEADER** interprets each accepted word as a packet header. It leaves by *payload-start* when the header carries a word count, or by *header-error* back to SEARCH when the header is malformed. A no-op or zero-count header keeps it in HEADER, which is *header-stay*.
- **PAYLOAD** routes words to the addressed register. It returns by *payload-done* when the count runs out. A session-end command takes *session-end* back to SEARCH.

A zero-count type-1 header remembers its target register. A type-2 header that follows it immediately can then carry a large count to that same register.

Top module: `cfg_pkt_decoder`

## Requirements
- R1: After reset the decoder is in SEARCH: `synced` and both error flags are 0, all register outputs and `cmd_pulse` are 0, and `in_ready` is 1.
- R2: In SEARCH every word is consumed with no effect on registers or strobes. The word 0xAA995566 moves the decoder to HEADER, and `synced` reads 1 from the next cycle on.
- R3: A type-1 write header has bits [31:29]=001, bits [28:27]=10, the register address in bits [17:13] and the word count in bits [10:0]. The addresses are checksum=0, frame address=1, frame data=2, command=4, control=5 and mask=6. The next count words are written to that register, and register outputs update one cycle after the word is accepted.
- R4: A type-2 write header has bits [31:29]=010, bits [28:27]=10 and the count in bits [26:0]. It is valid only as the word right after a type-1 write header, and its payload goes to that header's register. Otherwise it is a header error, even when only a no-op sits between the two headers.
- R5: A control write applies `ctl = (ctl & ~mask) | (data & mask)`. The mask resets to 0, so control writes have no effect until the mask has been written.
- R6: A command payload word gives a one-cycle pulse on `cmd_pulse` in the cycle after acceptance. The codes map to bits as follows: 1→bit0 (enable config writes), 3→bit1 (release global high), 5→bit2 (start-up), 9→bit3 (clock switch), 0xA→bit4 (global restore), 0xD→bit5 (session end). Any other code gives no pulse.
- R7: When the config-write enable is armed, each frame-data payload word appears on `frm_data` with `frm_valid`=1 and `frm_addr` equal to the frame-address register. Such a word is accepted only when `frm_ready`=1, so `in_ready` follows `frm_ready`. The enable is armed by command code 1 and cleared by any frame-address write.
- R8: A frame-data payload word that arrives while the enable is not armed is consumed with `in_ready`=1 and is not forwarded. It sets the sticky `err_frame` flag.
- R9: The word 0x20000000 (type 001, opcode 00) is a no-op header. It is consumed in HEADER with no payload and no effect on registers, strobes or errors.
- R10: Three kinds of header are errors: an unknown opcode or type, an unknown register address, or a misplaced type-2 header. Each one sets the sticky `err_header` flag and returns the decoder to SEARCH. Only reset clears the error flags.
- R11: The session-end command (code 0xD) returns the decoder to SEARCH. Words after it, such as no-ops or register writes, have no effect until the next synchronisation word.
- R12: A checksum register write is stored and shown on `crc_value`. It is not compared against any computed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Stream word |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Stream word accepted this cycle when valid |
| frm_data | output | 32 | Forwarded frame-data word |
| frm_addr | output | 32 | Frame address for the forwarded word |
| frm_valid | output | 1 | Frame-data word present |
| frm_ready | input | 1 | Downstream accepts frame data |
| cmd_pulse | output | 6 | One-hot command strobes |
| ctl_value | output | 32 | Control register |
| mask_value | output | 32 | Mask register |
| crc_value | output | 32 | Last checksum register write |
| far_value | output | 32 | Frame address register |
| synced | output | 1 | Decoder is out of SEARCH |
| err_header | output | 1 | Sticky malformed-header flag |
| err_frame | output | 1 | Sticky dropped-frame-data flag |

## Verification
The bench sends a mask/control pair while still in SEARCH and again after session end. A decoder that leaked payload outside a session would change the mask. It writes control before and after the mask is set, to catch a design that ignores the mask or resets it to all ones. It splits a zero-count frame-data header from its type-2 header with a no-op, and stalls the frame output mid-burst. These catch a decoder that loses the tracked register or drops and duplicates a word under backpressure. It also sends frame data after a frame-address write that disarmed the enable, which a design that never clears the enable would forward.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    localparam int DW       = 32;
    localparam int AW       = 5;
    localparam int CNT_W    = 27;
    localparam int T1_CNT_W = 11;
    localparam int NUM_CMD  = 6;

    localparam logic [DW-1:0] SYNC_WORD = 32'hAA995566;

    localparam logic [AW-1:0] RA_CRC  = 5'd0;
    localparam logic [AW-1:0] RA_FAR  = 5'd1;
    localparam logic [AW-1:0] RA_FDRI = 5'd2;
    localparam logic [AW-1:0] RA_CMD  = 5'd4;
    localparam logic [AW-1:0] RA_CTL  = 5'd5;
    localparam logic [AW-1:0] RA_MASK = 5'd6;

    localparam int CI_WCFG   = 0;
    localparam int CI_DESYNC = 5;

    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_HEADER  = 2'd1,
        ST_PAYLOAD = 2'd2
    } dec_state_e;

    typedef struct packed {
        logic             nop;
        logic             t1w;
        logic             t2w;
        logic             bad;
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] cnt;
    } hdr_t;

    function automatic logic [DW-1:0] cmd_code(input int idx);
        case (idx)
            0:       return 32'h1;
            1:       return 32'h3;
            2:       return 32'h5;
            3:       return 32'h9;
            4:       return 32'hA;
            default: return 32'hD;
        endcase
    endfunction

    function automatic logic reg_known(input logic [AW-1:0] a);
        return (a == RA_CRC) || (a == RA_FAR) || (a == RA_FDRI) ||
               (a == RA_CMD) || (a == RA_CTL) || (a == RA_MASK);
    endfunction

endpackage

// File: rtl/cfgdec_hdr.sv
module cfgdec_hdr
    import cfgdec_pkg::*;
(
    input  logic [DW-1:0] word,
    output hdr_t          info
);
    logic [2:0] kind;
    logic [1:0] opc;

    always_comb begin
        kind      = word[31:29];
        opc       = word[28:27];
        info      = '0;
        info.addr = word[17:13];
        info.nop  = (kind == 3'b001) && (opc == 2'b00);
        info.t1w  = (kind == 3'b001) && (opc == 2'b10) && reg_known(word[17:13]);
        info.t2w  = (kind == 3'b010) && (opc == 2'b10);
        if (info.t2w) begin
            info.cnt = word[CNT_W-1:0];
        end else begin
            info.cnt = {{(CNT_W-T1_CNT_W){1'b0}}, word[T1_CNT_W-1:0]};
        end
        info.bad  = !(info.nop || info.t1w || info.t2w);
    end
endmodule

// File: rtl/cfgdec_cmd.sv
module cfgdec_cmd
    import cfgdec_pkg::*;
#(
    parameter int N = NUM_CMD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [DW-1:0] code,
    output logic [N-1:0]  pulse,
    output logic [N-1:0]  hit
);
    for (genvar i = 0; i < N; i++) begin : g_code
        assign hit[i] = fire && (code == cmd_code(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= '0;
        else        pulse <= hit;
    end

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse)); // R6
    AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (pulse == '0)); // R6
endmodule

// File: rtl/cfgdec_regs.sv
module cfgdec_regs
    import cfgdec_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          arm,
    output logic [DW-1:0] ctl_q,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] crc_q,
    output logic [DW-1:0] far_q,
    output logic          armed
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            mask_q <= '0;
            crc_q  <= '0;
            far_q  <= '0;
            armed  <= 1'b0;
        end else begin
            if (arm) armed <= 1'b1;
            if (wr_en) begin
                unique case (wr_addr)
                    RA_CTL:  ctl_q  <= (ctl_q & ~mask_q) | (wr_data & mask_q);
                    RA_MASK: mask_q <= wr_data;
                    RA_CRC:  crc_q  <= wr_data;
                    RA_FAR: begin
                        far_q <= wr_data;
                        armed <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_CTL && mask_q == '0) |=> $stable(ctl_q)); // R5
    AST_FAR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_FAR) |=> !armed); // R7
endmodule

// File: rtl/cfg_pkt_decoder.sv
module cfg_pkt_decoder
    import cfgdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic [DW-1:0]       frm_data,
    output logic [DW-1:0]       frm_addr,
    output logic                frm_valid,
    input  logic                frm_ready,
    output logic [NUM_CMD-1:0]  cmd_pulse,
    output logic [DW-1:0]       ctl_value,
    output logic [DW-1:0]       mask_value,
    output logic [DW-1:0]       crc_value,
    output logic [DW-1:0]       far_value,
    output logic                synced,
    output logic                err_header,
    output logic                err_frame
);
    dec_state_e       state, nxt;
    logic [AW-1:0]    tgt;
    logic [CNT_W-1:0] cnt;
    logic             prev_t1;
    hdr_t             hdr;
    logic             acc, route_frm, armed;
    logic             pay_acc, reg_wr, cmd_fire, drop, hdr_err;
    logic [NUM_CMD-1:0] cmd_hit;

    cfgdec_hdr u_hdr (
        .word (in_data),
        .info (hdr)
    );

    assign route_frm = (state == ST_PAYLOAD) && (tgt == RA_FDRI);
    assign frm_valid = in_valid && route_frm && armed;
    assign frm_data  = in_data;
    assign frm_addr  = far_value;
    assign in_ready  = (route_frm && armed) ? frm_ready : 1'b1;
    assign acc       = in_valid && in_ready;
    assign pay_acc   = acc && (state == ST_PAYLOAD);
    assign reg_wr    = pay_acc && (tgt != RA_FDRI);
    assign cmd_fire  = pay_acc && (tgt == RA_CMD);
    assign drop      = pay_acc && route_frm && !armed;
    assign hdr_err   = acc && (state == ST_HEADER) &&
                       (hdr.bad || (hdr.t2w && !prev_t1));
    assign synced    = (state != ST_SEARCH);

    cfgdec_cmd #(.N(NUM_CMD)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (cmd_fire),
        .code  (in_data),
        .pulse (cmd_pulse),
        .hit   (cmd_hit)
    );

    cfgdec_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (tgt),
        .wr_data (in_data),
        .arm     (cmd_hit[CI_WCFG]),
        .ctl_q   (ctl_value),
        .mask_q  (mask_value),
        .crc_q   (crc_value),
        .far_q   (far_value),
        .armed   (armed)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SEARCH;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SEARCH: begin
                if (acc && in_data == SYNC_WORD) nxt = ST_HEADER;
            end
            ST_HEADER: begin
                if (hdr_err) begin
                    nxt = ST_SEARCH;
                end else if (acc && (hdr.t1w || hdr.t2w) && hdr.cnt != '0) begin
                    nxt = ST_PAYLOAD;
                end
            end
            ST_PAYLOAD: begin
                if (acc) begin
                    if (cmd_hit[CI_DESYNC])  nxt = ST_SEARCH;
                    else if (cnt == 'd1)     nxt = ST_HEADER;
                end
            end
            default: nxt = ST_SEARCH;
        endcase
    end

    // datapath and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt        <= '0;
            cnt        <= '0;
            prev_t1    <= 1'b0;
            err_header <= 1'b0;
            err_frame  <= 1'b0;
        end else begin
            if (hdr_err) err_header <= 1'b1;
            if (drop)    err_frame  <= 1'b1;
            if (acc) begin
                prev_t1 <= (state == ST_HEADER) && hdr.t1w;
                if (state == ST_HEADER && !hdr_err) begin
                    if (hdr.t1w) tgt <= hdr.addr;
                    if (hdr.t1w || hdr.t2w) cnt <= hdr.cnt;
                end else if (state == ST_PAYLOAD) begin
                    cnt <= cnt - 'd1;
                end
            end
        end
    end

    AST_PAYLOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAYLOAD) |-> (cnt != '0)); // R3
    AST_END_TO_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse[CI_DESYNC] |-> (state == ST_SEARCH)); // R11
    AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_ready) |-> !in_ready); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_header |=> err_header); // R10
    AST_ERR_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |=> !synced); // R10
endmodule

// File: tb/sim_cfg_pkt_decoder.sv
`timescale 1ns/1ps
module sim_cfg_pkt_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] in_data;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] frm_data, frm_addr;
    logic        frm_valid, frm_ready;
    logic [5:0]  cmd_pulse;
    logic [31:0] ctl_value, mask_value, crc_value, far_value;
    logic        synced, err_header, err_frame;

    int checks = 0;
    int fails  = 0;
    int nfrm   = 0;
    logic [31:0] last_d = '0, last_a = '0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_pkt_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .frm_data(frm_data), .frm_addr(frm_addr),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .cmd_pulse(cmd_pulse),
        .ctl_value(ctl_value), .mask_value(mask_value), .crc_value(crc_value),
        .far_value(far_value), .synced(synced), .err_header(err_header),
        .err_frame(err_frame)
    );

    always @(posedge clk) begin
        if (frm_valid && frm_ready) begin
            nfrm   <= nfrm + 1;
            last_d <= frm_data;
            last_a <= frm_addr;
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] w);
        in_data  = w;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; frm_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 synced", {31'd0, synced}, 32'd0);
        check("R1 errors", {30'd0, err_header, err_frame}, 32'd0);
        check("R1 pulse", {26'd0, cmd_pulse}, 32'd0);
        check("R1 ctl", ctl_value, 32'd0);
        check("R1 ready", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_presync;
        put(32'h3000C001); put(32'hFFFFFFFF);
        check("R2 mask before sync", mask_value, 32'd0);
        check("R2 not synced", {31'd0, synced}, 32'd0);
        put(32'hAA995566);
        check("R2 synced", {31'd0, synced}, 32'd1);
    endtask

    task automatic t_nop;
        repeat (3) put(32'h20000000);
        check("R9 no error", {31'd0, err_header}, 32'd0);
        check("R9 still synced", {31'd0, synced}, 32'd1);
        check("R9 mask untouched", mask_value, 32'd0);
    endtask

    task automatic t_cmds;
        logic [31:0] codes [5];
        codes = '{32'h1, 32'h3, 32'h5, 32'h9, 32'hA};
        for (int i = 0; i < 5; i++) begin
            put(32'h30008001); put(codes[i]);
            check("R6 strobe", {26'd0, cmd_pulse}, 32'd1 << i);
        end
        put(32'h30008001); put(32'h7);
        check("R6 unknown code", {26'd0, cmd_pulse}, 32'd0);
    endtask

    task automatic t_mask;
        put(32'h3000A001); put(32'h000000FF);
        check("R5 ctl with zero mask", ctl_value, 32'd0);
        put(32'h3000C001); put(32'h00000008);
        put(32'h3000A001); put(32'h000000FF);
        check("R5 ctl masked", ctl_value, 32'h8);
        put(32'h3000C001); put(32'h000000F0);
        put(32'h3000A001); put(32'h0000005A);
        check("R5 ctl merge", ctl_value, 32'h58);
    endtask

    task automatic t_frames;
        int base;
        put(32'h30002001); put(32'h00000040);
        check("R3 far", far_value, 32'h40);
        base = nfrm;
        put(32'h30004002); put(32'hAAA1); put(32'hAAA2);
        check("R8 not forwarded", nfrm - base, 32'd0);
        check("R8 err_frame", {31'd0, err_frame}, 32'd1);
        check("R8 no header error", {31'd0, err_header}, 32'd0);
        put(32'h30008001); put(32'h1);
        base = nfrm;
        put(32'h30004000); put(32'h50000003);
        put(32'h111);
        frm_ready = 1'b0;
        in_data = 32'h222; in_valid = 1'b1;
        #1;
        check("R7 stalled ready", {31'd0, in_ready}, 32'd0);
        check("R7 frame valid", {31'd0, frm_valid}, 32'd1);
        @(negedge clk);
        frm_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        put(32'h333);
        check("R4 count of frames", nfrm - base, 32'd3);
        check("R7 last data", last_d, 32'h333);
        check("R7 frame address", last_a, 32'h40);
        put(32'h20000000);
        check("R4 back to header", {30'd0, synced, err_header}, 32'd2);
    endtask

    task automatic t_crc;
        put(32'h30000001); put(32'h0000DEFC);
        check("R12 crc", crc_value, 32'hDEFC);
    endtask

    task automatic t_desync;
        put(32'h30008001); put(32'hD);
        check("R6 session end strobe", {26'd0, cmd_pulse}, 32'h20);
        check("R11 left session", {31'd0, synced}, 32'd0);
        put(32'h20000000); put(32'h3000C001); put(32'h0000FFFF);
        check("R11 trailing ignored", mask_value, 32'hF0);
        check("R11 still searching", {31'd0, synced}, 32'd0);
    endtask

    task automatic t_errors;
        do_reset();
        check("R1 errors cleared", {30'd0, err_header, err_frame}, 32'd0);
        put(32'hAA995566); put(32'h50000004);
        check("R10 lone type2", {31'd0, err_header}, 32'd1);
        check("R10 to search", {31'd0, synced}, 32'd0);
        put(32'hAA995566); put(32'h28002001);
        check("R10 read opcode", {31'd0, synced}, 32'd0);
        put(32'hAA995566); put(32'h30006001);
        check("R10 unknown register", {31'd0, synced}, 32'd0);
        put(32'hAA995566); put(32'h30004000); put(32'h20000000); put(32'h50000002);
        check("R4 type2 after nop", {31'd0, synced}, 32'd0);
        check("R10 sticky", {31'd0, err_header}, 32'd1);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_presync();
        t_nop();
        t_cmds();
        t_mask();
        t_frames();
        t_crc();
        t_desync();
        t_errors();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule